// File: doc/BRIEF.md
# Half-Duplex Byte Mailbox

This block is a single-byte exchange point between two agents, called the host side and the device side. Each side has a write strobe with a data byte, a read view of the mailbox and a flag that says a byte from the other side is waiting. Only one direction holds a byte at any time. When one side deposits a byte, the other side sees it, and the depositing side reads zero until the other side writes back. Traffic therefore alternates strictly, one turn per side.

Zero has a special meaning: it is the "nothing here" value. A zero byte can never be sent. Writing zero is ignored. A side that writes again before it gets a reply is also ignored. Because of these two rules, a side's read view only ever moves from zero to a byte, or from a byte back to zero. It never jumps from one nonzero byte to a different one. If both sides make a valid write in the same cycle while the mailbox is empty, the host's byte is kept.

Top module: `duplex_mailbox`

## Requirements
- R1: After reset, both read views are 0x00, both waiting flags are low, and either side may write first.
- R2: A nonzero host write that is accepted is visible in the next cycle. The device view shows the byte and the device flag is high. The host view reads 0x00 and the host flag is low.
- R3: A nonzero device write that is accepted is visible in the next cycle. The host view shows the byte and the host flag is high. The device view reads 0x00 and the device flag is low.
- R4: A write of 0x00 from either side is ignored and leaves both views and both flags unchanged.
- R5: A write from the side whose byte is still pending is ignored, so the other side keeps seeing the first byte.
- R6: A reply from the receiving side replaces the pending byte and reverses the direction. The original sender then sees the reply, and the replier reads 0x00.
- R7: If both sides make a nonzero write in the same cycle while the mailbox is empty, the host's byte is kept. If the host's byte is pending and both write, the device's reply is taken.
- R8: A side's read view never changes directly from one nonzero value to a different nonzero value. At most one view is nonzero at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | DATA_W | Host byte to deposit |
| hostRdData | output | DATA_W | Host view: the device's byte, or 0x00 |
| hostMsgWaiting | output | 1 | A byte from the device is waiting for the host |
| devWrEn | input | 1 | Device write strobe |
| devWrData | input | DATA_W | Device byte to deposit |
| devRdData | output | DATA_W | Device view: the host's byte, or 0x00 |
| devMsgWaiting | output | 1 | A byte from the host is waiting for the device |

## Verification
The assertions assume that reset is asserted from time zero. They also assume that both write strobes and data buses hold known values at every clock edge, and that the strobes may be high in any combination, in any cycle, with zero data. The stimulus drives every input on the falling edge and keeps them all defined. It deliberately mixes zero writes, repeated writes by the pending side, simultaneous writes and a mid-run reset, so the ordering properties are exercised without ever leaving that assumed input space.

// File: rtl/mailbox_pkg.sv
package mailbox_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_DEV  = 2'd2
  } owner_t;

  typedef struct packed {
    logic loadHost;
    logic loadDev;
    logic showHost;
    logic showDev;
  } mbox_strobe_t;
endpackage

// File: rtl/mailbox_ctrl.sv
module mailbox_ctrl
  import mailbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              devWrEn,
  input  logic [DATA_W-1:0] devWrData,
  output mbox_strobe_t      strobes
);
  owner_t owner;
  logic hostReq, devReq, hostAcc, devAcc;

  assign hostReq = hostWrEn && (hostWrData != '0);
  assign devReq  = devWrEn  && (devWrData  != '0);
  assign hostAcc = hostReq && (owner != OWN_HOST);
  assign devAcc  = devReq  && (owner != OWN_DEV) && !hostAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owner <= OWN_NONE;
    end else if (hostAcc) begin
      owner <= OWN_HOST;
    end else if (devAcc) begin
      owner <= OWN_DEV;
    end
  end

  always_comb begin
    strobes.loadHost = hostAcc;
    strobes.loadDev  = devAcc;
    strobes.showHost = (owner == OWN_DEV);
    strobes.showDev  = (owner == OWN_HOST);
  end

  assert_host_send_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostWrData != '0 && owner != OWN_HOST) |=> owner == OWN_HOST);

  assert_dev_send_R3: assert property (@(posedge clk) disable iff (!rstN)
    (devWrEn && devWrData != '0 && owner == OWN_HOST) |=> owner == OWN_DEV);

  assert_zero_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!(hostWrEn && hostWrData != '0) && !(devWrEn && devWrData != '0)) |=> $stable(owner));

  assert_repeat_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_HOST && !(devWrEn && devWrData != '0)) |=> owner == OWN_HOST);
endmodule

// File: rtl/mailbox_datapath.sv
module mailbox_datapath
  import mailbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbox_strobe_t      strobes,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] devWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic [DATA_W-1:0] devRdData
);
  logic [DATA_W-1:0] slotByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotByte <= '0;
    end else if (strobes.loadHost) begin
      slotByte <= hostWrData;
    end else if (strobes.loadDev) begin
      slotByte <= devWrData;
    end
  end

  assign hostRdData = strobes.showHost ? slotByte : '0;
  assign devRdData  = strobes.showDev  ? slotByte : '0;

  assert_views_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(hostRdData != '0 && devRdData != '0));

  assert_host_view_steady_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdData != '0 && $past(hostRdData) != '0) |-> hostRdData == $past(hostRdData));

  assert_dev_view_steady_R8: assert property (@(posedge clk) disable iff (!rstN)
    (devRdData != '0 && $past(devRdData) != '0) |-> devRdData == $past(devRdData));

  assert_reply_turn_R6: assert property (@(posedge clk) disable iff (!rstN)
    (devRdData != '0 && strobes.loadDev) |=> devRdData == '0);
endmodule

// File: rtl/duplex_mailbox.sv
module duplex_mailbox
  import mailbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostMsgWaiting,
  input  logic              devWrEn,
  input  logic [DATA_W-1:0] devWrData,
  output logic [DATA_W-1:0] devRdData,
  output logic              devMsgWaiting
);
  mbox_strobe_t strobes;

  mailbox_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .devWrEn(devWrEn), .devWrData(devWrData),
    .strobes(strobes)
  );

  mailbox_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .hostWrData(hostWrData), .devWrData(devWrData),
    .hostRdData(hostRdData), .devRdData(devRdData)
  );

  assign hostMsgWaiting = strobes.showHost;
  assign devMsgWaiting  = strobes.showDev;
endmodule

// File: tb/test_duplex_mailbox.sv
module test_duplex_mailbox;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0, devWrEn = 1'b0;
  logic [W-1:0] hostWrData = '0, devWrData = '0;
  logic [W-1:0] hostRdData, devRdData;
  logic hostMsgWaiting, devMsgWaiting;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int mOwner = 0;   // 0 empty, 1 host pending, 2 device pending
  int mByte = 0;

  always #2.5 clk = ~clk;

  duplex_mailbox #(.DATA_W(W)) i_duplex_mailbox (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .hostMsgWaiting(hostMsgWaiting),
    .devWrEn(devWrEn), .devWrData(devWrData), .devRdData(devRdData),
    .devMsgWaiting(devMsgWaiting)
  );

  task automatic compare(input string tag);
    int expHost = (mOwner == 2) ? mByte : 0;
    int expDev  = (mOwner == 1) ? mByte : 0;
    checks++;
    if (int'(hostRdData) != expHost || int'(devRdData) != expDev ||
        hostMsgWaiting != (mOwner == 2) || devMsgWaiting != (mOwner == 1)) begin
      failures++;
      $display("FAIL %s: host=%0h/%0b dev=%0h/%0b expected host=%0h/%0b dev=%0h/%0b",
               tag, hostRdData, hostMsgWaiting, devRdData, devMsgWaiting,
               expHost, mOwner == 2, expDev, mOwner == 1);
    end
  endtask

  task automatic step(input bit he, input int hd, input bit de, input int dd,
                      input string tag);
    bit hReq = he && (hd != 0);
    bit dReq = de && (dd != 0);
    hostWrEn = he; hostWrData = W'(hd);
    devWrEn = de; devWrData = W'(dd);
    @(posedge clk);
    if (hReq && mOwner != 1) begin
      mOwner = 1; mByte = hd;
    end else if (dReq && mOwner != 2) begin
      mOwner = 2; mByte = dd;
    end
    @(negedge clk);
    hostWrEn = 0; devWrEn = 0;
    compare(tag);
  endtask

  task automatic doReset();
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    mOwner = 0; mByte = 0;
    compare("R1");
    rstN = 1;
    @(negedge clk);
    compare("R1");
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    step(1, 8'h5A, 0, 0, "R2");
    step(0, 0, 0, 0, "R2");
    step(1, 8'h33, 0, 0, "R5");
    step(1, 0, 0, 0, "R4");
    step(0, 0, 1, 0, "R4");
    step(0, 0, 1, 8'hA5, "R6");
    step(0, 0, 1, 8'h44, "R5");
    step(0, 0, 0, 0, "R3");
    step(1, 8'h12, 1, 8'h77, "R6");
    step(1, 8'h99, 1, 8'h66, "R7");
    step(0, 0, 1, 8'hFF, "R8");
    doReset();
    step(1, 8'h81, 1, 8'h18, "R7");
    doReset();
    step(0, 0, 1, 8'h01, "R3");
    step(1, 8'hFE, 0, 0, "R6");
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 15);
      step(r[0], (r[1] ? $urandom_range(0, 255) : 0),
           r[2], (r[3] ? $urandom_range(0, 255) : 0), "R8");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule